// File: doc/BRIEF.md
# Software-Set Interrupt Request Register

This block holds seven interrupt request flags that software sets and clears through a 16-bit register port. Each flag stands for one priority level, from 1 (lowest) to 7 (highest). The register reports the number of the highest pending level in two identical read-only 3-bit fields. It also drives an interrupt request toward the processor whenever that level is above the processor's current priority.

Software raises a request by writing the register with a word or a byte access. The processor's interrupt logic answers with an acknowledge pulse. That pulse withdraws the flag of the level being serviced, and the next lower pending level then becomes visible. Read data is combinational, and full words and either byte lane can be read.

Top module: `pir_register`

## Requirements
- R1: A word write (busSel=1, busWr=1, busByte=0) loads the request flags from write data bits 15:9, with bit 9 standing for level 1 and bit 15 for level 7. The other written bits are ignored. The new flags and their encoding are visible from the cycle after the write edge.
- R2: In a word read, bits 7:5 and bits 3:1 both hold the number of the highest pending level, or 0 when no flag is set. Bits 15:9 read back the flags.
- R3: Bits 8, 4 and 0 of the read word are always zero.
- R4: A byte read (busByte=1) with busOdd=0 returns bits 7:0 on busRdata[7:0], and with busOdd=1 returns bits 15:8 there. busRdata[15:8] is zero in a byte read.
- R5: A byte write with busOdd=1 loads the flags for levels 1 to 7 from write data bits 1 to 7. A byte write with busOdd=0 changes nothing.
- R6: irqLevel equals the highest pending level. irqReq is 1 exactly when that level is strictly greater than cpuLevel.
- R7: irqAck clears the flag of the level shown on irqLevel, and the fields show the result one cycle later. An acknowledge with no pending level has no effect.
- R8: When a write and irqAck come in the same cycle, the write takes effect and the acknowledge is dropped.
- R9: Reset (rstN=0) clears every request flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busByte | input | 1 | 1 for byte access, 0 for word |
| busOdd | input | 1 | Byte lane select: 1 selects the high byte |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, zero when no read is selected |
| cpuLevel | input | 3 | Current processor priority level |
| irqAck | input | 1 | Acknowledge of the level on irqLevel |
| irqReq | output | 1 | Interrupt request to the processor |
| irqLevel | output | 3 | Highest pending level |

## Verification
The bench attacks priority resolution while several flags are set. A wrong encoder would report a lower flag or an OR of the level numbers, and the acknowledge would then clear the wrong flag. It checks that byte writes to the low lane change nothing and that odd-lane writes shift into bits 15:9. A design that decoded the lanes the wrong way round would overwrite flags from the read-only byte. It also checks an acknowledge that collides with a write, and the strict comparison against cpuLevel when the two levels are equal, where an off-by-one compare would raise a spurious request.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int LEVELS  = 7;
  localparam int LVL_W   = $clog2(LEVELS + 1);
  localparam int DATA_W  = 16;
  localparam int REQ_LSB = DATA_W - LEVELS;   // flags sit in the top bits
  localparam int HI_LSB  = 5;                 // upper copy of the encoding
  localparam int LO_LSB  = 1;                 // lower copy of the encoding
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic loadReq;     // replace the flags this cycle
    logic srcLowByte;  // take new flags from the low data byte
    logic clearTop;    // drop the highest pending flag
    logic rdEn;        // drive read data
    logic rdByte;      // byte read
    logic rdHigh;      // byte read of the upper lane
  } pirStrobes_t;
endpackage

// File: rtl/pir_control.sv
module pir_control
  import pir_pkg::*;
(
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busByte,
  input  logic             busOdd,
  input  logic             irqAck,
  input  logic [LVL_W-1:0] encLevel,
  input  logic [LVL_W-1:0] cpuLevel,
  output pirStrobes_t      strobes,
  output logic             irqReq
);
  logic writeAny;
  logic writeHits;

  always_comb begin
    writeAny  = busSel && busWr;
    // the low byte is entirely read-only, so only that lane is dropped
    writeHits = writeAny && (!busByte || busOdd);

    strobes            = '0;
    strobes.loadReq    = writeHits;
    strobes.srcLowByte = busByte;
    // an acknowledge colliding with any write is dropped
    strobes.clearTop   = irqAck && !writeAny && (encLevel != '0);
    strobes.rdEn       = busSel && !busWr;
    strobes.rdByte     = busByte;
    strobes.rdHigh     = busOdd;
  end

  assign irqReq = encLevel > cpuLevel;
endmodule

// File: rtl/pir_datapath.sv
module pir_datapath
  import pir_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pirStrobes_t       strobes,
  input  logic [DATA_W-1:0] wData,
  output logic [LVL_W-1:0]  encLevel,
  output logic [DATA_W-1:0] rData
);
  logic [LEVELS-1:0] reqBits;
  logic [LEVELS-1:0] newBits;
  logic [LEVELS-1:0] topMask;
  logic [DATA_W-1:0] wordView;

  // new flag source: upper lane of a word, or the high byte carried low
  always_comb begin
    if (strobes.srcLowByte)
      newBits = wData[LEVELS:1];
    else
      newBits = wData[DATA_W-1:REQ_LSB];
  end

  // priority encoder, highest set flag wins
  always_comb begin
    encLevel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (reqBits[i]) encLevel = LVL_W'(i + 1);
    end
  end

  // one-hot mask of the flag currently shown
  generate
    for (genvar g = 0; g < LEVELS; g++) begin : gMask
      assign topMask[g] = (encLevel == LVL_W'(g + 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      reqBits <= '0;
    else if (strobes.loadReq)
      reqBits <= newBits;
    else if (strobes.clearTop)
      reqBits <= reqBits & ~topMask;
  end

  always_comb begin
    wordView = '0;
    wordView[DATA_W-1:REQ_LSB]       = reqBits;
    wordView[HI_LSB +: LVL_W]        = encLevel;
    wordView[LO_LSB +: LVL_W]        = encLevel;
  end

  always_comb begin
    rData = '0;
    if (strobes.rdEn) begin
      if (!strobes.rdByte)
        rData = wordView;
      else if (strobes.rdHigh)
        rData[BYTE_W-1:0] = wordView[DATA_W-1:BYTE_W];
      else
        rData[BYTE_W-1:0] = wordView[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/pir_register.sv
module pir_register
  import pir_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busByte,
  input  logic              busOdd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LVL_W-1:0]  cpuLevel,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [LVL_W-1:0]  irqLevel
);
  pirStrobes_t      strobes;
  logic [LVL_W-1:0] encLevel;

  pir_control u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busByte  (busByte),
    .busOdd   (busOdd),
    .irqAck   (irqAck),
    .encLevel (encLevel),
    .cpuLevel (cpuLevel),
    .strobes  (strobes),
    .irqReq   (irqReq)
  );

  pir_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wData    (busWdata),
    .encLevel (encLevel),
    .rData    (busRdata)
  );

  assign irqLevel = encLevel;
endmodule

// File: rtl/pir_checker.sv
module pir_checker
  import pir_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic              busByte,
  input logic              irqAck,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqReq,
  input logic [LVL_W-1:0]  irqLevel
);
  logic wordRead, byteRead, anyWrite;
  assign wordRead = busSel && !busWr && !busByte;
  assign byteRead = busSel && !busWr && busByte;
  assign anyWrite = busSel && busWr;

  AST_FIELDS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    wordRead |-> busRdata[HI_LSB +: LVL_W] == busRdata[LO_LSB +: LVL_W]); // R2
  AST_FIELD_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    wordRead |-> busRdata[LO_LSB +: LVL_W] == irqLevel); // R2
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    wordRead |-> (busRdata[8] == 1'b0 && busRdata[4] == 1'b0 && busRdata[0] == 1'b0)); // R3
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    byteRead |-> busRdata[DATA_W-1:BYTE_W] == '0); // R4
  AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqLevel != '0); // R6
  AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !anyWrite && irqLevel != '0) |=> irqLevel < $past(irqLevel)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!irqAck && !anyWrite) |=> $stable(irqLevel)); // R1
endmodule

bind pir_register pir_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busByte  (busByte),
  .irqAck   (irqAck),
  .busRdata (busRdata),
  .irqReq   (irqReq),
  .irqLevel (irqLevel)
);

// File: tb/sim_pir_register.sv
`timescale 1ns/1ps
module sim_pir_register;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busByte = 1'b0, busOdd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [2:0]  cpuLevel = '0;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [2:0]  irqLevel;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pir_register u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busByte(busByte),
    .busOdd(busOdd), .busWdata(busWdata), .busRdata(busRdata),
    .cpuLevel(cpuLevel), .irqAck(irqAck), .irqReq(irqReq), .irqLevel(irqLevel)
  );

  // op: 0 word write, 1 byte write, 2 acknowledge
  typedef struct packed {
    logic [1:0]  op;
    logic        odd;
    logic [15:0] wdata;
    logic [2:0]  pri;
    logic [15:0] expRd;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 16'hFFFF, 3'd6, 16'hFEEE, 1'b1},  // R1 all levels, top = 7
    '{2'd2, 1'b0, 16'h0000, 3'd6, 16'h7ECC, 1'b0},  // R7 ack clears 7; R6 equal level
    '{2'd0, 1'b0, 16'h0200, 3'd0, 16'h0222, 1'b1},  // R1 level 1 only
    '{2'd0, 1'b0, 16'h01FF, 3'd0, 16'h0000, 1'b0},  // R1 low bits ignored
    '{2'd1, 1'b1, 16'h0014, 3'd3, 16'h1488, 1'b1},  // R5 odd byte -> levels 4,2
    '{2'd1, 1'b0, 16'h00FF, 3'd4, 16'h1488, 1'b0},  // R5 even byte ignored
    '{2'd2, 1'b0, 16'h0000, 3'd1, 16'h0444, 1'b1},  // R7 clear 4, level 2 left
    '{2'd2, 1'b0, 16'h0000, 3'd0, 16'h0000, 1'b0},  // R7 clear 2
    '{2'd2, 1'b0, 16'h0000, 3'd0, 16'h0000, 1'b0},  // R7 ack with nothing pending
    '{2'd0, 1'b0, 16'h8000, 3'd7, 16'h80EE, 1'b0}   // R2 level 7, R6 not above 7
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic odd, input logic [15:0] wd, input logic ack);
    @(negedge clk);
    busSel = (op != 2'd2); busWr = (op != 2'd2); busByte = (op == 2'd1);
    busOdd = odd; busWdata = wd; irqAck = ack || (op == 2'd2);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busByte = 1'b0; busOdd = 1'b0; irqAck = 1'b0;
  endtask

  task automatic readAs(input logic isByte, input logic odd, output logic [15:0] val);
    busSel = 1'b1; busWr = 1'b0; busByte = isByte; busOdd = odd;
    #1 val = busRdata;
    busSel = 1'b0; busByte = 1'b0; busOdd = 1'b0;
  endtask

  initial begin
    #20000;
    nFails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    readAs(1'b0, 1'b0, v);
    check("R9 reset read", v, 16'h0000);
    check("R6 reset irq", {15'd0, irqReq}, 16'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cpuLevel = VECS[i].pri;
      doOp(VECS[i].op, VECS[i].odd, VECS[i].wdata, 1'b0);
      readAs(1'b0, 1'b0, v);
      check($sformatf("R2 vector %0d word", i), v, VECS[i].expRd);
      check($sformatf("R6 vector %0d irq", i), {15'd0, irqReq}, {15'd0, VECS[i].expIrq});
      check($sformatf("R6 vector %0d level", i), {13'd0, irqLevel}, {13'd0, VECS[i].expRd[3:1]});
    end

    // R4 byte lanes with level 7 pending (word 80EE)
    readAs(1'b1, 1'b0, v);
    check("R4 even byte", v, 16'h00EE);
    readAs(1'b1, 1'b1, v);
    check("R4 odd byte", v, 16'h0080);

    // R3 word write with bits 8,4,0 and the fields set
    cpuLevel = 3'd2;
    doOp(2'd0, 1'b0, 16'h09FF, 1'b0);
    readAs(1'b0, 1'b0, v);
    check("R3 zero bits", v, 16'h0866);
    check("R6 level 3 above 2", {15'd0, irqReq}, 16'd1);

    // R8 write and ack together: write wins
    doOp(2'd0, 1'b0, 16'h2800, 1'b1);
    readAs(1'b0, 1'b0, v);
    check("R8 write beats ack", v, 16'h28AA);

    // R7 ack visible one cycle later, not in the ack cycle
    @(negedge clk);
    irqAck = 1'b1;
    #1 check("R7 level before edge", {13'd0, irqLevel}, 16'd5);
    @(negedge clk);
    irqAck = 1'b0;
    #1 check("R7 level after edge", {13'd0, irqLevel}, 16'd3);

    // R9 reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    readAs(1'b0, 1'b0, v);
    check("R9 reset clears", v, 16'h0000);
    rstN = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule